// File: doc/BRIEF.md
# Tamper Event Timestamp Capture

This block freezes a copy of the running calendar time when a tamper event occurs. The time counter outside the block supplies six live BCD fields: second, minute, hour, day of month, month (encoded 1 to 12) and year. When a qualified event arrives, the block copies all six fields in the same clock edge and holds them on its outputs. A qualified event is a synchronised tamper pulse, or a battery switch-over pulse when that source is enabled. Software reads and clears the result through a small byte-wide register port.

Two event flags record that a capture happened. They sit in two different control registers, and software clears each one by writing 0 to it. A policy bit picks between two modes. In keep-first mode the earliest event is held until both flags have been cleared. In overwrite mode every event replaces the stored time. An off bit disables capture entirely. An interrupt enable drives an active-low request while either flag is set. This request models an open-drain line and may be left unconnected.

Top module: `ts_capture`

## Requirements
- R1: After reset, all six captured fields read 0, both flags are 0, `irq_no` is 1, and every register reads 0.
- R2: A `tamper_i` pulse, when capture is on, loads all six live fields into the captured outputs at that clock edge. The values appear on the outputs the cycle after the pulse, and both flags are set.
- R3: Keep-first mode is bit 7 of the timestamp config register (address 3). When it is 1 and either flag is set, an event changes neither the captured fields nor the flags.
- R4: When timestamp config bit 7 is 0, each event overwrites the captured fields and sets both flags again.
- R5: When timestamp config bit 6 (off) is 1, no event changes the captured fields or the flags.
- R6: Writing 0 to bit 4 of control register A (address 0) clears flag A. Writing 0 to bit 5 of control register B (address 1) clears flag B. Writing 1 to either bit leaves that flag unchanged. In keep-first mode, capture rearms only once both flags are 0.
- R7: `irq_no` is 0 exactly when bit 2 of control register B is 1 and at least one flag is set. Otherwise it is 1.
- R8: A `batt_sw_i` pulse captures only while bit 4 of control register C (address 2) is 1. When that bit is 0, the pulse has no effect.
- R9: An event in the same cycle as a flag-clearing write is judged against the flags after the clear. If the event is captured, both flags end set.
- R10: `reg_rdata_o` is combinational from `reg_addr_i`. Address 0 returns flag A at bit 4. Address 1 returns flag B at bit 5 and the interrupt enable at bit 2. Address 2 returns the battery enable at bit 4. Address 3 returns keep-first at bit 7 and off at bit 6. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| live_sec_i | input | 8 | Live seconds, BCD |
| live_min_i | input | 8 | Live minutes, BCD |
| live_hour_i | input | 8 | Live hours, BCD |
| live_day_i | input | 8 | Live day of month, BCD |
| live_mon_i | input | 8 | Live month 1 to 12, BCD |
| live_year_i | input | 8 | Live year, BCD |
| tamper_i | input | 1 | Synchronised tamper pulse, one cycle |
| batt_sw_i | input | 1 | Battery switch-over pulse, one cycle |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| cap_sec_o | output | 8 | Captured seconds |
| cap_min_o | output | 8 | Captured minutes |
| cap_hour_o | output | 8 | Captured hours |
| cap_day_o | output | 8 | Captured day of month |
| cap_mon_o | output | 8 | Captured month |
| cap_year_o | output | 8 | Captured year |
| flag_a_o | output | 1 | Event flag in control register A |
| flag_b_o | output | 1 | Event flag in control register B |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with its default 8-bit fields and 2-bit register address. At that size the whole policy space can be swept. The sweep covers every combination of keep-first, off, battery enable, trigger source and whether a prior capture is pending, and the expected fields, flags and request are computed for each case. Directed sequences then cover the single-flag clear that must not rearm, an event in the same cycle as a clear, the interrupt enable, and register readback.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int FIELD_W    = 8;
  localparam int N_FIELDS   = 6;
  localparam int REG_ADDR_W = 2;
  localparam int REG_DATA_W = 8;

  localparam logic [REG_ADDR_W-1:0] ADDR_CTL_A  = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_CTL_B  = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_CTL_C  = 2'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_TS_CFG = 2'd3;

  localparam int BIT_FLAG_A     = 4;
  localparam int BIT_FLAG_B     = 5;
  localparam int BIT_IRQ_EN     = 2;
  localparam int BIT_BATT_EN    = 4;
  localparam int BIT_KEEP_FIRST = 7;
  localparam int BIT_TS_OFF     = 6;

  typedef struct packed {
    logic keep_first;
    logic ts_off;
    logic batt_en;
    logic irq_en;
  } ts_cfg_t;
endpackage

// File: rtl/ts_regs.sv
module ts_regs
  import ts_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [REG_DATA_W-1:0] wdata_i,
  input  logic                  cap_stb_i,
  output ts_cfg_t               cfg_o,
  output logic                  flag_a_o,
  output logic                  flag_b_o,
  output logic                  clr_a_o,
  output logic                  clr_b_o,
  output logic [REG_DATA_W-1:0] rdata_o
);
  ts_cfg_t cfg_q;
  logic    flag_a_q, flag_b_q;
  logic    wr_a, wr_b, wr_c, wr_ts;

  assign wr_a  = we_i && (addr_i == ADDR_CTL_A);
  assign wr_b  = we_i && (addr_i == ADDR_CTL_B);
  assign wr_c  = we_i && (addr_i == ADDR_CTL_C);
  assign wr_ts = we_i && (addr_i == ADDR_TS_CFG);

  // software clears by writing zero; writing one keeps the flag
  assign clr_a_o = wr_a && !wdata_i[BIT_FLAG_A];
  assign clr_b_o = wr_b && !wdata_i[BIT_FLAG_B];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else begin
      if (wr_b)  cfg_q.irq_en  <= wdata_i[BIT_IRQ_EN];
      if (wr_c)  cfg_q.batt_en <= wdata_i[BIT_BATT_EN];
      if (wr_ts) begin
        cfg_q.keep_first <= wdata_i[BIT_KEEP_FIRST];
        cfg_q.ts_off     <= wdata_i[BIT_TS_OFF];
      end
    end
  end

  // capture outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_a_q <= 1'b0;
      flag_b_q <= 1'b0;
    end else begin
      if (cap_stb_i)    flag_a_q <= 1'b1;
      else if (clr_a_o) flag_a_q <= 1'b0;
      if (cap_stb_i)    flag_b_q <= 1'b1;
      else if (clr_b_o) flag_b_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTL_A:  rdata_o[BIT_FLAG_A] = flag_a_q;
      ADDR_CTL_B: begin
        rdata_o[BIT_FLAG_B] = flag_b_q;
        rdata_o[BIT_IRQ_EN] = cfg_q.irq_en;
      end
      ADDR_CTL_C:  rdata_o[BIT_BATT_EN] = cfg_q.batt_en;
      default: begin
        rdata_o[BIT_KEEP_FIRST] = cfg_q.keep_first;
        rdata_o[BIT_TS_OFF]     = cfg_q.ts_off;
      end
    endcase
  end

  assign cfg_o    = cfg_q;
  assign flag_a_o = flag_a_q;
  assign flag_b_o = flag_b_q;
endmodule

// File: rtl/ts_trigger.sv
module ts_trigger
  import ts_pkg::*;
(
  input  logic    tamper_i,
  input  logic    batt_sw_i,
  input  ts_cfg_t cfg_i,
  input  logic    flag_a_i,
  input  logic    flag_b_i,
  input  logic    clr_a_i,
  input  logic    clr_b_i,
  output logic    cap_stb_o
);
  logic event_hit, rearmed;

  assign event_hit = tamper_i || (batt_sw_i && cfg_i.batt_en);
  // flags as they stand after this cycle's clear
  assign rearmed   = (!flag_a_i || clr_a_i) && (!flag_b_i || clr_b_i);
  assign cap_stb_o = !cfg_i.ts_off && event_hit && (!cfg_i.keep_first || rearmed);
endmodule

// File: rtl/ts_store.sv
module ts_store #(
  parameter int FIELD_W  = 8,
  parameter int N_FIELDS = 6
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              cap_stb_i,
  input  logic [N_FIELDS-1:0][FIELD_W-1:0]  live_i,
  output logic [N_FIELDS-1:0][FIELD_W-1:0]  held_o
);
  for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        held_o[g] <= '0;
      else if (cap_stb_i) held_o[g] <= live_i[g];
    end
  end
endmodule

// File: rtl/ts_capture.sv
module ts_capture
  import ts_pkg::*;
#(
  parameter int FW = FIELD_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [FW-1:0]         live_sec_i,
  input  logic [FW-1:0]         live_min_i,
  input  logic [FW-1:0]         live_hour_i,
  input  logic [FW-1:0]         live_day_i,
  input  logic [FW-1:0]         live_mon_i,
  input  logic [FW-1:0]         live_year_i,
  input  logic                  tamper_i,
  input  logic                  batt_sw_i,
  input  logic                  reg_we_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [REG_DATA_W-1:0] reg_wdata_i,
  output logic [REG_DATA_W-1:0] reg_rdata_o,
  output logic [FW-1:0]         cap_sec_o,
  output logic [FW-1:0]         cap_min_o,
  output logic [FW-1:0]         cap_hour_o,
  output logic [FW-1:0]         cap_day_o,
  output logic [FW-1:0]         cap_mon_o,
  output logic [FW-1:0]         cap_year_o,
  output logic                  flag_a_o,
  output logic                  flag_b_o,
  output logic                  irq_no
);
  ts_cfg_t                         cfg;
  logic                            clr_a, clr_b, cap_stb;
  logic                            keep_first_q, ts_off_q;
  logic [N_FIELDS-1:0][FW-1:0]     live, held;

  assign live = {live_sec_i, live_min_i, live_hour_i, live_day_i, live_mon_i, live_year_i};

  ts_regs i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .cap_stb_i (cap_stb),
    .cfg_o     (cfg),
    .flag_a_o  (flag_a_o),
    .flag_b_o  (flag_b_o),
    .clr_a_o   (clr_a),
    .clr_b_o   (clr_b),
    .rdata_o   (reg_rdata_o)
  );

  ts_trigger i_trigger (
    .tamper_i  (tamper_i),
    .batt_sw_i (batt_sw_i),
    .cfg_i     (cfg),
    .flag_a_i  (flag_a_o),
    .flag_b_i  (flag_b_o),
    .clr_a_i   (clr_a),
    .clr_b_i   (clr_b),
    .cap_stb_o (cap_stb)
  );

  ts_store #(.FIELD_W(FW), .N_FIELDS(N_FIELDS)) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_stb_i (cap_stb),
    .live_i    (live),
    .held_o    (held)
  );

  assign {cap_sec_o, cap_min_o, cap_hour_o, cap_day_o, cap_mon_o, cap_year_o} = held;

  assign keep_first_q = cfg.keep_first;
  assign ts_off_q     = cfg.ts_off;
  assign irq_no       = !(cfg.irq_en && (flag_a_o || flag_b_o));
endmodule

// File: rtl/ts_capture_chk.sv
module ts_capture_chk #(
  parameter int CW = 48
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tamper_i,
  input logic          batt_sw_i,
  input logic          reg_we_i,
  input logic [1:0]    reg_addr_i,
  input logic [7:0]    reg_wdata_i,
  input logic          keep_first_i,
  input logic          ts_off_i,
  input logic [CW-1:0] cap_i,
  input logic          flag_a_i,
  input logic          flag_b_i,
  input logic          irq_ni
);
  p_no_event_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tamper_i && !batt_sw_i |=> $stable(cap_i));

  p_flags_rise_together_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_a_i) |-> flag_b_i);

  p_keep_first_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    keep_first_i && flag_a_i && flag_b_i && !reg_we_i |=> $stable(cap_i) && flag_a_i && flag_b_i);

  p_off_blocks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_off_i && !reg_we_i |=> $stable(cap_i) && !$rose(flag_a_i) && !$rose(flag_b_i));

  p_clear_a_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == 2'd0 && !reg_wdata_i[4] && !tamper_i && !batt_sw_i |=> !flag_a_i);

  p_irq_needs_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_ni |-> (flag_a_i || flag_b_i));
endmodule

bind ts_capture ts_capture_chk #(.CW(6*FW)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tamper_i     (tamper_i),
  .batt_sw_i    (batt_sw_i),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .keep_first_i (keep_first_q),
  .ts_off_i     (ts_off_q),
  .cap_i        ({cap_sec_o, cap_min_o, cap_hour_o, cap_day_o, cap_mon_o, cap_year_o}),
  .flag_a_i     (flag_a_o),
  .flag_b_i     (flag_b_o),
  .irq_ni       (irq_no)
);

// File: tb/test_ts_capture.sv
`timescale 1ns/1ps
module test_ts_capture;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sec, mn, hr, dy, mo, yr;
  logic       tamper = 1'b0, batt = 1'b0, we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [7:0] c_sec, c_min, c_hour, c_day, c_mon, c_year;
  logic       fa, fb, irq_n;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [47:0] exp_f;

  always #5 clk = ~clk;

  ts_capture i_ts_capture (
    .clk_i(clk), .rst_ni(rst_n),
    .live_sec_i(sec), .live_min_i(mn), .live_hour_i(hr),
    .live_day_i(dy), .live_mon_i(mo), .live_year_i(yr),
    .tamper_i(tamper), .batt_sw_i(batt),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .cap_sec_o(c_sec), .cap_min_o(c_min), .cap_hour_o(c_hour),
    .cap_day_o(c_day), .cap_mon_o(c_mon), .cap_year_o(c_year),
    .flag_a_o(fa), .flag_b_o(fb), .irq_no(irq_n)
  );

  function automatic logic [7:0] bcd(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic logic [47:0] tstamp(int k);
    return {bcd(k % 60), bcd((k * 7) % 60), bcd(k % 24),
            bcd(k % 28 + 1), bcd(k % 12 + 1), bcd((k * 3) % 100)};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic set_time(int k);
    {sec, mn, hr, dy, mo, yr} = tstamp(k);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  // src 0: tamper, 1: battery switch
  task automatic fire(int src, int k);
    @(negedge clk);
    set_time(k);
    if (src == 0) tamper = 1'b1; else batt = 1'b1;
    @(negedge clk);
    tamper = 1'b0; batt = 1'b0;
    set_time(k + 500);
  endtask

  function automatic logic [47:0] caps();
    return {c_sec, c_min, c_hour, c_day, c_mon, c_year};
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    set_time(0);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 fields", caps(), 48'd0);
    check("R1 flags", {fa, fb}, 2'b00);
    check("R1 irq", irq_n, 1'b1);
    addr = 2'd3; #1;
    check("R1 cfg reg", rdata, 8'h00);
    rst_n = 1'b1;
    exp_f = 48'd0;

    // sweep: keep_first, off, batt_en, source, prior capture pending
    for (int i = 0; i < 32; i++) begin
      int m = (i >> 4) & 1, off = (i >> 3) & 1, be = (i >> 2) & 1;
      int src = (i >> 1) & 1, prior = i & 1;
      bit trig, cap;
      string tag;
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h04);
      wr(2'd3, 8'(m << 7));
      wr(2'd2, 8'h00);
      if (prior != 0) begin
        fire(0, 2 * i + 1);
        exp_f = tstamp(2 * i + 1);
      end
      wr(2'd3, 8'((m << 7) | (off << 6)));
      wr(2'd2, 8'(be << 4));
      fire(src, 2 * i + 2);
      trig = (src == 0) || (be != 0);
      cap  = trig && (off == 0) && !((m != 0) && (prior != 0));
      if (cap) exp_f = tstamp(2 * i + 2);
      if (off != 0)                 tag = "R5";
      else if (src != 0 && be == 0) tag = "R8";
      else if (m != 0 && prior != 0) tag = "R3";
      else if (m == 0 && prior != 0) tag = "R4";
      else                           tag = "R2";
      check({tag, " fields"}, caps(), exp_f);
      check({tag, " flags"}, {fa, fb}, {2{cap || (prior != 0)}});
      check("R7 irq in sweep", irq_n, !(cap || (prior != 0)));
    end

    // R6: writing 1 keeps flags; single clear does not rearm keep-first
    wr(2'd0, 8'h00); wr(2'd1, 8'h04);
    wr(2'd3, 8'h80);
    fire(0, 700); exp_f = tstamp(700);
    wr(2'd0, 8'h10);
    wr(2'd1, 8'h24);
    check("R6 write one keeps", {fa, fb}, 2'b11);
    wr(2'd0, 8'h00);
    check("R6 clear a only", {fa, fb}, 2'b01);
    fire(0, 701);
    check("R6 not rearmed fields", caps(), exp_f);
    check("R6 not rearmed flags", {fa, fb}, 2'b01);
    wr(2'd1, 8'h04);
    check("R6 both cleared", {fa, fb}, 2'b00);
    fire(0, 702); exp_f = tstamp(702);
    check("R6 rearmed", caps(), exp_f);

    // R9: event in the cycle of a clear
    @(negedge clk);
    we = 1'b1; addr = 2'd0; wdata = 8'h00; set_time(703); tamper = 1'b1;
    @(negedge clk);
    we = 1'b0; tamper = 1'b0;
    check("R9 b still set blocks", caps(), exp_f);
    check("R9 b still set flags", {fa, fb}, 2'b01);
    @(negedge clk);
    we = 1'b1; addr = 2'd1; wdata = 8'h04; set_time(704); tamper = 1'b1;
    @(negedge clk);
    we = 1'b0; tamper = 1'b0;
    exp_f = tstamp(704);
    check("R9 last clear rearms", caps(), exp_f);
    check("R9 flags set", {fa, fb}, 2'b11);

    // R7: enable off masks request
    wr(2'd1, 8'h20);
    check("R7 irq disabled", irq_n, 1'b1);
    wr(2'd1, 8'h24);
    check("R7 irq enabled", irq_n, 1'b0);

    // R10 readback
    wr(2'd3, 8'hFF);
    wr(2'd2, 8'hFF);
    @(negedge clk);
    addr = 2'd0; #1; check("R10 ctl a", rdata, 8'h10);
    addr = 2'd1; #1; check("R10 ctl b", rdata, 8'h24);
    addr = 2'd2; #1; check("R10 ctl c", rdata, 8'h10);
    addr = 2'd3; #1; check("R10 ts cfg", rdata, 8'hC0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule